// File: doc/BRIEF.md
# Camera Pixel Capture Front End

This block takes the byte stream of a CMOS image sensor into a system clock domain. The sensor drives a pixel clock, an 8-bit data bus and two data-enable lines. On every rising pixel-clock edge the block registers the bus and both enables in the pixel domain. It then hands that sample to the system clock with a toggle handshake. All the remaining decisions are made on the system side: whether the sample qualifies, whether decimation keeps it, and where it goes in the word.

A qualified sample can be thinned to one in two, keeping either the even or the odd positions. This is useful, for example, to keep only the luma bytes of an interleaved YUV 4:2:2 stream. Kept bytes are packed little-endian into an 8-, 16- or 32-bit word. When a word completes it is copied into a holding register and a ready flag rises. A read strobe lowers the flag. If a new word completes while the flag is still high, the new word overwrites the holding register and a sticky overrun flag is set. Configuration comes in on plain input ports and is applied in the system domain.

Top module: `cam_capture`

## Requirements
- R1: Each rising edge of `pix_clk` registers `pix_data`, `pix_en_a` and `pix_en_b`, and that sample reaches the system domain. No sample is lost while `clk` runs at least three times faster than `pix_clk`.
- R2: With `qual_bypass`=0, a sample qualifies only if `pix_en_a` and `pix_en_b` were both 1 at its pixel-clock edge.
- R3: With `qual_bypass`=1, every sample qualifies whatever the enables are.
- R4: With `decim_en`=0, every qualified sample is kept. With `decim_en`=1, qualified samples are numbered 0,1,2,… from the moment capture is enabled. Only even numbers are kept when `decim_odd`=0, and only odd numbers when `decim_odd`=1. Samples that do not qualify do not advance the numbering.
- R5: `word_size` selects the word: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Kept bytes fill the word little-endian (the first byte goes to [7:0], the next to [15:8], and so on). Bits above the selected size read 0.
- R6: The packing position and the decimation numbering restart whenever `cap_en` is low, so a partly filled word is discarded.
- R7: When a word completes, `word_out` takes the word and `word_valid` becomes 1 on the next clock. `rd_pop` clears `word_valid` unless another word completes in the same cycle.
- R8: If a word completes while `word_valid`=1 and `rd_pop`=0, the new word replaces `word_out` and `overrun` becomes 1. `overrun` stays 1 until `ovr_clr` is pulsed, and the clear has priority.
- R9: While `cap_en`=0 no sample is accepted and `word_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pix_clk | input | 1 | Sensor pixel clock |
| pix_data | input | 8 | Sensor data bus |
| pix_en_a | input | 1 | First sensor data enable |
| pix_en_b | input | 1 | Second sensor data enable |
| cap_en | input | 1 | Capture enable |
| qual_bypass | input | 1 | 1: ignore the enables |
| decim_en | input | 1 | 1: keep one of two qualified samples |
| decim_odd | input | 1 | Decimation phase: 0 keeps even, 1 keeps odd |
| word_size | input | 2 | Word size code |
| rd_pop | input | 1 | Read strobe, clears `word_valid` |
| ovr_clr | input | 1 | Clears `overrun` |
| word_out | output | 32 | Holding register |
| word_valid | output | 1 | Word ready flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is one where decimation interacts with qualification. The numbering must skip samples that do not qualify, and it must also restart when capture is re-enabled. To reach it, the bench drives the pixel clock by hand and sets the enables per byte. It mixes unqualified bytes into a decimated stream and toggles `cap_en` in the middle of a word. It then checks that the packed word contains only the bytes the index rule allows.

// File: rtl/cam_capture.sv
module cam_capture #(
  parameter int PIX_W = 8,
  localparam int NBYTES = 4,
  localparam int WORD_W = PIX_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_en_a,
  input  logic              pix_en_b,
  input  logic              cap_en,
  input  logic              qual_bypass,
  input  logic              decim_en,
  input  logic              decim_odd,
  input  logic [1:0]        word_size,
  input  logic              rd_pop,
  input  logic              ovr_clr,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              overrun
);

  logic [PIX_W-1:0]  px_q;
  logic              px_a, px_b, px_tog;
  logic [2:0]        tog_sync;
  logic              evt, qual, keep, done;
  logic              idx_odd;
  logic [1:0]        pos, last_pos;
  logic [WORD_W-1:0] acc, nxt, mask;

  always_ff @(posedge pix_clk or negedge rst_n)
    if (!rst_n) begin
      px_q <= '0; px_a <= 1'b0; px_b <= 1'b0; px_tog <= 1'b0;
    end else begin
      px_q <= pix_data; px_a <= pix_en_a; px_b <= pix_en_b; px_tog <= ~px_tog;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tog_sync <= '0;
    else        tog_sync <= {tog_sync[1:0], px_tog};

  assign evt      = tog_sync[2] ^ tog_sync[1];
  assign qual     = cap_en & evt & (qual_bypass | (px_a & px_b));
  assign keep     = qual & (~decim_en | (idx_odd == decim_odd));
  assign last_pos = (word_size == 2'd0) ? 2'd0 : (word_size == 2'd1) ? 2'd1 : 2'd3;
  assign done     = keep & (pos == last_pos);

  always_comb begin
    nxt = acc;
    nxt[pos*PIX_W +: PIX_W] = px_q;
    for (int b = 0; b < NBYTES; b++)
      mask[b*PIX_W +: PIX_W] = {PIX_W{(2'(b) <= last_pos)}};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos <= '0; idx_odd <= 1'b0; acc <= '0; word_out <= '0; word_valid <= 1'b0;
    end else if (!cap_en) begin
      pos <= '0; idx_odd <= 1'b0; word_valid <= 1'b0;
    end else begin
      if (qual) idx_odd <= ~idx_odd;
      if (keep) begin
        acc <= nxt;
        pos <= done ? 2'd0 : pos + 2'd1;
      end
      if (done) word_out <= nxt & mask;
      word_valid <= done ? 1'b1 : (rd_pop ? 1'b0 : word_valid);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              overrun <= 1'b0;
    else if (ovr_clr)                        overrun <= 1'b0;
    else if (done && word_valid && !rd_pop)  overrun <= 1'b1;

  AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !word_valid); // R9
  AST_OFF_POS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> (pos == 2'd0 && !idx_odd)); // R6
  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && rd_pop && !done) |=> !word_valid); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun); // R8
  AST_OVR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(word_valid)); // R8
  always_comb AST_POS_IN_WORD: assert (!rst_n || pos <= last_pos || !cap_en); // R5

endmodule

// File: tb/cam_capture_bench.sv
module cam_capture_bench;
  logic clk = 0, rst_n = 0, pix_clk = 0;
  logic [7:0] pix_data = 0;
  logic pix_en_a = 0, pix_en_b = 0, cap_en = 0, qual_bypass = 0;
  logic decim_en = 0, decim_odd = 0, rd_pop = 0, ovr_clr = 0;
  logic [1:0] word_size = 0;
  logic [31:0] word_out;
  logic word_valid, overrun;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cam_capture u_cam_capture (.clk, .rst_n, .pix_clk, .pix_data, .pix_en_a, .pix_en_b,
    .cap_en, .qual_bypass, .decim_en, .decim_odd, .word_size, .rd_pop, .ovr_clr,
    .word_out, .word_valid, .overrun);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic px(logic [7:0] d, logic ea, logic eb);
    pix_data = d; pix_en_a = ea; pix_en_b = eb;
    #50 pix_clk = 1;
    #50 pix_clk = 0;
    #100;
  endtask

  task automatic setup(logic byp, logic dec, logic odd, logic [1:0] sz);
    @(negedge clk) cap_en = 0;
    repeat (2) @(negedge clk);
    qual_bypass = byp; decim_en = dec; decim_odd = odd; word_size = sz;
    cap_en = 1;
    @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk) rd_pop = 1;
    @(negedge clk) rd_pop = 0;
  endtask

  task automatic t_reset();
    chk("R7 reset valid", word_valid, 0);
    chk("R8 reset overrun", overrun, 0);
  endtask

  task automatic t_basic();
    setup(1, 0, 0, 2'd0);
    px(8'hA5, 0, 0);
    @(negedge clk);
    chk("R1 byte word", word_out, 32'h0000_00A5);
    chk("R7 valid set", word_valid, 1);
    pop();
    chk("R7 pop clears", word_valid, 0);
  endtask

  task automatic t_qual();
    setup(0, 0, 0, 2'd1);
    px(8'h11, 1, 0); px(8'h22, 1, 1); px(8'h33, 0, 1); px(8'h44, 1, 1);
    @(negedge clk);
    chk("R2 qualified pack", word_out, 32'h0000_4422);
    chk("R2 valid", word_valid, 1);
  endtask

  task automatic t_bypass();
    setup(1, 0, 0, 2'd2);
    px(8'h11, 1, 0); px(8'h22, 0, 0); px(8'h33, 0, 1); px(8'h44, 1, 1);
    @(negedge clk);
    chk("R3 R5 bypass 32", word_out, 32'h4433_2211);
  endtask

  task automatic t_decim();
    setup(1, 1, 0, 2'd1);
    px(8'h10, 0, 0); px(8'h20, 0, 0); px(8'h30, 0, 0); px(8'h40, 0, 0);
    @(negedge clk);
    chk("R4 even", word_out, 32'h0000_3010);
    setup(1, 1, 1, 2'd1);
    px(8'h10, 0, 0); px(8'h20, 0, 0); px(8'h30, 0, 0); px(8'h40, 0, 0);
    @(negedge clk);
    chk("R4 odd", word_out, 32'h0000_4020);
    setup(0, 1, 0, 2'd0);
    px(8'hA1, 1, 1); px(8'hB2, 0, 1); px(8'hC3, 1, 1);
    @(negedge clk);
    chk("R4 unqualified not counted", word_out, 32'h0000_00A1);
    pop();
    px(8'hD4, 1, 1);
    @(negedge clk);
    chk("R4 index 2 kept", word_out, 32'h0000_00D4);
    chk("R4 valid", word_valid, 1);
  endtask

  task automatic t_restart();
    setup(1, 0, 0, 2'd1);
    px(8'h55, 0, 0);
    setup(1, 0, 0, 2'd1);
    px(8'h66, 0, 0); px(8'h77, 0, 0);
    @(negedge clk);
    chk("R6 restart pack", word_out, 32'h0000_7766);
  endtask

  task automatic t_disabled();
    setup(1, 0, 0, 2'd0);
    @(negedge clk) cap_en = 0;
    px(8'h99, 1, 1); px(8'h98, 1, 1);
    chk("R9 no ready off", word_valid, 0);
    @(negedge clk) cap_en = 1;
    @(negedge clk);
    chk("R9 nothing pending", word_valid, 0);
    px(8'h3C, 0, 0);
    @(negedge clk);
    chk("R9 fresh byte", word_out, 32'h0000_003C);
  endtask

  task automatic t_overrun();
    setup(1, 0, 0, 2'd0);
    px(8'h01, 0, 0);
    chk("R8 no overrun yet", overrun, 0);
    px(8'h02, 0, 0);
    @(negedge clk);
    chk("R8 overwrite", word_out, 32'h0000_0002);
    chk("R8 overrun set", overrun, 1);
    pop();
    chk("R8 pop leaves overrun", overrun, 1);
    chk("R7 popped", word_valid, 0);
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;
    chk("R8 clear", overrun, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_qual();
    t_bypass();
    t_decim();
    t_restart();
    t_disabled();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule